// File: doc/BRIEF.md
# Garbage-collection copy-back sequencer with selective write-back path

This block drives one flash channel through the relocation phase of garbage collection. It receives a bitmap of the pages still live in a victim block. It walks that bitmap from the lowest page upward. For each live page, it first loads the page from flash into the channel's local page buffer. It then ships the page over a request/response link to a shared error-check agent and waits for the verdict.

The verdict picks the return path. A clean page is programmed into the next free destination page straight from the local buffer: no data comes back from the agent and no queue entry is made. A page that needed correction takes the long route. The sequencer waits for the corrected data to arrive, posts one garbage-collection write task into the shared task queue (stalling while the queue is full), and only then programs the page. When the bitmap is exhausted, the victim block is erased and a done pulse reports how many pages took each path. If the destination block has no free page left for a page that is still live, the pass stops early, raises a flag and skips the erase.

Flash read, program and erase times are parameters in clock cycles. The sequencer issues a one-cycle command and then waits out that time itself.

Top module: `gc_copyback_ctrl`

## Requirements
- R1: After `start_i`, read commands (`nand_op_o` = 2'b01) are issued only for pages whose bit in `valid_map_i` is set, each exactly once, in ascending page order. `nand_page_o` carries the page number.
- R2: `chk_req_o` rises exactly RD_CYC+1 cycles after the read command for that page. It then stays high, with `chk_page_o` stable, until a cycle with `chk_req_ready_i` high.
- R3: On a response with `chk_rsp_err_i` = 0, the write command (`nand_op_o` = 2'b10) follows in the cycle after the response. It has `nand_wsrc_o` = 0 (data from the local buffer), and no task entry is pushed.
- R4: On a response with `chk_rsp_err_i` = 1, no write is issued until `fix_valid_i` has been seen and one task entry has been accepted. The write then has `nand_wsrc_o` = 1 (corrected data).
- R5: `tq_valid_o` stays high with `tq_page_o` stable until `tq_ready_i` is high, so no entry is dropped. Exactly one entry is accepted per corrected page, and it carries the destination page of that page's write.
- R6: Write destinations start at page 0 on every pass and increase by one per write.
- R7: After the last live page, one erase command (`nand_op_o` = 2'b11) is issued. `done_o` pulses for one cycle exactly ER_CYC+1 cycles later. At that point `clean_cnt_o` and `fixed_cnt_o` hold the per-path page counts, and they keep those values until the next start.
- R8: If a live page remains after `dst_free_i` writes, `dst_full_o` is set, no further read or erase command is issued, and `done_o` pulses. `dst_full_o` clears on the next start.
- R9: `start_i` is ignored while `busy_o` is high.
- R10: After reset, `busy_o`, `done_o`, `nand_cmd_o`, `chk_req_o`, `tq_valid_o` and `dst_full_o` are 0, and both counts are 0.
- R11: After a write command, no other flash command is issued for at least WR_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pass; sampled only when idle |
| valid_map_i | input | PAGES | Live-page bitmap of the victim block |
| dst_free_i | input | CNT_W | Free pages available in the destination block |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| clean_cnt_o | output | CNT_W | Pages written back from the local buffer |
| fixed_cnt_o | output | CNT_W | Pages written back with corrected data |
| dst_full_o | output | 1 | Destination ran out of pages during the pass |
| nand_cmd_o | output | 1 | One-cycle flash command strobe |
| nand_op_o | output | 2 | 01 read, 10 write, 11 erase |
| nand_page_o | output | IDX_W | Source page for read, destination page for write, 0 for erase |
| nand_wsrc_o | output | 1 | Write data source: 0 local buffer, 1 corrected data |
| chk_req_o | output | 1 | Check request to the error-check agent |
| chk_req_ready_i | input | 1 | Agent accepts the request |
| chk_page_o | output | IDX_W | Page being checked |
| chk_rsp_valid_i | input | 1 | Verdict valid |
| chk_rsp_err_i | input | 1 | Verdict: 1 when errors were found and corrected |
| fix_valid_i | input | 1 | Corrected page has arrived |
| tq_valid_o | output | 1 | Task entry valid |
| tq_ready_i | input | 1 | Task queue can accept |
| tq_page_o | output | IDX_W | Destination page of the queued write |

## Verification
Live-page bitmaps are run with all pages clean, all pages in error, and a mixed pattern. Together these separate the two write-back paths and show that the queue sees only corrected pages. Sparse maps with the first and last page, an empty map, and an exact-fit destination check the scan order and the erase-only pass. Destination limits that are too small, including zero, separate the early stop from a normal finish. A second start pulse in the middle of a pass shows that the running pass keeps its own inputs. Throughout, the agent accepts requests only on every third cycle and the queue holds off each push, so the request and push handshakes must wait.

// File: rtl/gc_cb_pkg.sv
package gc_cb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_RD_CMD, S_RD_WAIT, S_REQ, S_RSP, S_FIX,
    S_PUSH, S_WR_CMD, S_WR_WAIT, S_ER_CMD, S_ER_WAIT, S_DONE
  } gc_state_e;

  localparam logic [1:0] OP_NONE = 2'b00;
  localparam logic [1:0] OP_RD   = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b10;
  localparam logic [1:0] OP_ER   = 2'b11;
endpackage

// File: rtl/gc_page_picker.sv
module gc_page_picker #(
  parameter int unsigned PAGES = 64,
  parameter int unsigned IDX_W = $clog2(PAGES)
) (
  input  logic [PAGES-1:0] map_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = |map_i;
    idx_o   = '0;
    for (int i = PAGES - 1; i >= 0; i--) begin
      if (map_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/gc_delay_timer.sv
module gc_delay_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/gc_copyback_ctrl.sv
module gc_copyback_ctrl
  import gc_cb_pkg::*;
#(
  parameter int unsigned PAGES  = 64,
  parameter int unsigned RD_CYC = 6250,
  parameter int unsigned WR_CYC = 50000,
  parameter int unsigned ER_CYC = 175000,
  parameter int unsigned IDX_W  = $clog2(PAGES),
  parameter int unsigned CNT_W  = $clog2(PAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAGES-1:0] valid_map_i,
  input  logic [CNT_W-1:0] dst_free_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] clean_cnt_o,
  output logic [CNT_W-1:0] fixed_cnt_o,
  output logic             dst_full_o,
  output logic             nand_cmd_o,
  output logic [1:0]       nand_op_o,
  output logic [IDX_W-1:0] nand_page_o,
  output logic             nand_wsrc_o,
  output logic             chk_req_o,
  input  logic             chk_req_ready_i,
  output logic [IDX_W-1:0] chk_page_o,
  input  logic             chk_rsp_valid_i,
  input  logic             chk_rsp_err_i,
  input  logic             fix_valid_i,
  output logic             tq_valid_o,
  input  logic             tq_ready_i,
  output logic [IDX_W-1:0] tq_page_o
);
  localparam int unsigned MAX_RW  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned MAX_CYC = (MAX_RW > ER_CYC) ? MAX_RW : ER_CYC;
  localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] RD_LD = TMR_W'(RD_CYC - 1);
  localparam logic [TMR_W-1:0] WR_LD = TMR_W'(WR_CYC - 1);
  localparam logic [TMR_W-1:0] ER_LD = TMR_W'(ER_CYC - 1);

  gc_state_e        state_q;
  logic [PAGES-1:0] rem_q;
  logic [IDX_W-1:0] cur_page_q;
  logic [CNT_W-1:0] dst_ptr_q, dst_lim_q, clean_q, fixed_q;
  logic             full_q, cur_err_q;

  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  gc_page_picker #(.PAGES(PAGES), .IDX_W(IDX_W)) picker_i (
    .map_i   (rem_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_comb begin
    tmr_load = 1'b1;
    unique case (state_q)
      S_RD_CMD: tmr_val = RD_LD;
      S_WR_CMD: tmr_val = WR_LD;
      S_ER_CMD: tmr_val = ER_LD;
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  gc_delay_timer #(.W(TMR_W)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      rem_q      <= '0;
      cur_page_q <= '0;
      dst_ptr_q  <= '0;
      dst_lim_q  <= '0;
      clean_q    <= '0;
      fixed_q    <= '0;
      full_q     <= 1'b0;
      cur_err_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          rem_q     <= valid_map_i;
          dst_lim_q <= dst_free_i;
          dst_ptr_q <= '0;
          clean_q   <= '0;
          fixed_q   <= '0;
          full_q    <= 1'b0;
          state_q   <= S_SCAN;
        end
        S_SCAN: begin
          if (!pick_found) begin
            state_q <= S_ER_CMD;
          end else if (dst_ptr_q == dst_lim_q) begin
            // live page left but nowhere to put it: stop, keep victim
            full_q  <= 1'b1;
            state_q <= S_DONE;
          end else begin
            cur_page_q      <= pick_idx;
            rem_q[pick_idx] <= 1'b0;
            state_q         <= S_RD_CMD;
          end
        end
        S_RD_CMD:  state_q <= S_RD_WAIT;
        S_RD_WAIT: if (tmr_zero) state_q <= S_REQ;
        S_REQ:     if (chk_req_ready_i) state_q <= S_RSP;
        S_RSP: if (chk_rsp_valid_i) begin
          cur_err_q <= chk_rsp_err_i;
          state_q   <= chk_rsp_err_i ? S_FIX : S_WR_CMD;
        end
        S_FIX:  if (fix_valid_i) state_q <= S_PUSH;
        S_PUSH: if (tq_ready_i) state_q <= S_WR_CMD;
        S_WR_CMD: begin
          dst_ptr_q <= dst_ptr_q + 1'b1;
          if (cur_err_q) fixed_q <= fixed_q + 1'b1;
          else           clean_q <= clean_q + 1'b1;
          state_q <= S_WR_WAIT;
        end
        S_WR_WAIT: if (tmr_zero) state_q <= S_SCAN;
        S_ER_CMD:  state_q <= S_ER_WAIT;
        S_ER_WAIT: if (tmr_zero) state_q <= S_DONE;
        S_DONE:    state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      S_RD_CMD: nand_op_o = OP_RD;
      S_WR_CMD: nand_op_o = OP_WR;
      S_ER_CMD: nand_op_o = OP_ER;
      default:  nand_op_o = OP_NONE;
    endcase
  end

  assign nand_cmd_o  = (nand_op_o != OP_NONE);
  assign nand_page_o = (state_q == S_WR_CMD) ? dst_ptr_q[IDX_W-1:0] :
                       (state_q == S_RD_CMD) ? cur_page_q : '0;
  assign nand_wsrc_o = (state_q == S_WR_CMD) && cur_err_q;
  assign chk_req_o   = (state_q == S_REQ);
  assign chk_page_o  = cur_page_q;
  assign tq_valid_o  = (state_q == S_PUSH);
  assign tq_page_o   = dst_ptr_q[IDX_W-1:0];
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign clean_cnt_o = clean_q;
  assign fixed_cnt_o = fixed_q;
  assign dst_full_o  = full_q;
endmodule

// File: rtl/gc_copyback_chk.sv
module gc_copyback_chk #(
  parameter int unsigned PAGES  = 64,
  parameter int unsigned WR_CYC = 50000,
  parameter int unsigned IDX_W  = $clog2(PAGES),
  parameter int unsigned CNT_W  = $clog2(PAGES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             dst_full_o,
  input logic             nand_cmd_o,
  input logic [1:0]       nand_op_o,
  input logic [IDX_W-1:0] nand_page_o,
  input logic             nand_wsrc_o,
  input logic             chk_req_o,
  input logic             chk_req_ready_i,
  input logic [IDX_W-1:0] chk_page_o,
  input logic             tq_valid_o,
  input logic             tq_ready_i,
  input logic [IDX_W-1:0] tq_page_o
);
  localparam int unsigned GAP_W = $clog2(WR_CYC + 1);

  logic             pushed_q;
  logic [CNT_W-1:0] wr_seen_q, rd_floor_q;
  logic [GAP_W-1:0] wr_gap_q;
  logic             rd_cmd, wr_cmd, er_cmd;

  assign rd_cmd = nand_cmd_o && (nand_op_o == 2'b01);
  assign wr_cmd = nand_cmd_o && (nand_op_o == 2'b10);
  assign er_cmd = nand_cmd_o && (nand_op_o == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pushed_q   <= 1'b0;
      wr_seen_q  <= '0;
      rd_floor_q <= '0;
      wr_gap_q   <= GAP_W'(WR_CYC);
    end else begin
      if (tq_valid_o && tq_ready_i) pushed_q <= 1'b1;
      else if (wr_cmd)              pushed_q <= 1'b0;
      if (done_o)      wr_seen_q <= '0;
      else if (wr_cmd) wr_seen_q <= wr_seen_q + 1'b1;
      if (done_o)      rd_floor_q <= '0;
      else if (rd_cmd) rd_floor_q <= CNT_W'(nand_page_o) + 1'b1;
      if (wr_cmd)                           wr_gap_q <= '0;
      else if (wr_gap_q != GAP_W'(WR_CYC))  wr_gap_q <= wr_gap_q + 1'b1;
    end
  end

  // R1
  rd_ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd |-> (CNT_W'(nand_page_o) >= rd_floor_q));

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_req_o && !chk_req_ready_i) |=> (chk_req_o && $stable(chk_page_o)));

  // R4
  fixed_needs_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && nand_wsrc_o) |-> pushed_q);

  // R3
  clean_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !nand_wsrc_o) |-> !pushed_q);

  // R5
  tq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_valid_o && !tq_ready_i) |=> (tq_valid_o && $stable(tq_page_o)));

  // R6
  dst_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |-> (CNT_W'(nand_page_o) == wr_seen_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  no_erase_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_cmd |-> !dst_full_o);

  // R11
  wr_busy_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_cmd_o |-> (32'(wr_gap_q) >= WR_CYC));
endmodule

bind gc_copyback_ctrl gc_copyback_chk #(
  .PAGES(PAGES), .WR_CYC(WR_CYC), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .done_o          (done_o),
  .dst_full_o      (dst_full_o),
  .nand_cmd_o      (nand_cmd_o),
  .nand_op_o       (nand_op_o),
  .nand_page_o     (nand_page_o),
  .nand_wsrc_o     (nand_wsrc_o),
  .chk_req_o       (chk_req_o),
  .chk_req_ready_i (chk_req_ready_i),
  .chk_page_o      (chk_page_o),
  .tq_valid_o      (tq_valid_o),
  .tq_ready_i      (tq_ready_i),
  .tq_page_o       (tq_page_o)
);

// File: tb/gc_copyback_ctrl_tb_top.sv
module gc_copyback_ctrl_tb_top;
  localparam int PAGES = 64;
  localparam int RD = 5;
  localparam int WR = 8;
  localparam int ER = 12;
  localparam int NV = 7;

  // stimulus: live map, error map, free pages; expected: clean, fixed, full
  localparam logic [63:0] T_VMAP [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hA5A5_0F0F_8001_3C3C, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_00FF, 64'h0, 64'h1};
  localparam logic [63:0] T_EMAP [NV] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0F0F_0F0F_0F0F_0F0F, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0055, 64'h0, 64'h1};
  localparam int T_FREE  [NV] = '{64, 64, 64, 2, 5, 10, 0};
  localparam int T_CLEAN [NV] = '{64, 0, 9, 1, 2, 0, 0};
  localparam int T_FIXED [NV] = '{0, 64, 17, 1, 3, 0, 0};
  localparam int T_FULL  [NV] = '{0, 0, 0, 0, 1, 0, 1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [63:0] valid_map_i = '0;
  logic [6:0] dst_free_i = '0;
  logic busy_o, done_o, dst_full_o, nand_cmd_o, nand_wsrc_o, chk_req_o, tq_valid_o;
  logic [6:0] clean_cnt_o, fixed_cnt_o;
  logic [1:0] nand_op_o;
  logic [5:0] nand_page_o, chk_page_o, tq_page_o;
  logic chk_req_ready_i = 1'b0, chk_rsp_valid_i = 1'b0, chk_rsp_err_i = 1'b0;
  logic fix_valid_i = 1'b0, tq_ready_i = 1'b0;

  always #2 clk = ~clk;

  gc_copyback_ctrl #(.PAGES(PAGES), .RD_CYC(RD), .WR_CYC(WR), .ER_CYC(ER)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .valid_map_i(valid_map_i),
    .dst_free_i(dst_free_i), .busy_o(busy_o), .done_o(done_o),
    .clean_cnt_o(clean_cnt_o), .fixed_cnt_o(fixed_cnt_o), .dst_full_o(dst_full_o),
    .nand_cmd_o(nand_cmd_o), .nand_op_o(nand_op_o), .nand_page_o(nand_page_o),
    .nand_wsrc_o(nand_wsrc_o), .chk_req_o(chk_req_o), .chk_req_ready_i(chk_req_ready_i),
    .chk_page_o(chk_page_o), .chk_rsp_valid_i(chk_rsp_valid_i), .chk_rsp_err_i(chk_rsp_err_i),
    .fix_valid_i(fix_valid_i), .tq_valid_o(tq_valid_o), .tq_ready_i(tq_ready_i),
    .tq_page_o(tq_page_o));

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // bench model of the running pass
  logic [63:0] exp_rem = '0, cur_emap = '0;
  int wr_idx = 0, n_rd = 0, n_wr = 0, n_er = 0, n_tq = 0;
  int rd_stamp = -1, er_stamp = -1, wr_stamp = -1, rsp_stamp = -1, fix_stamp = -1;
  int last_page = 0, tq_wait = 0, rsp_timer = -1, fix_timer = -1, rsp_page = 0;
  bit pushed = 0, req_prev = 0, chk_pend = 0, tq_pend = 0;
  logic [5:0] chk_pend_page = '0, tq_pend_page = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (chk_pend) begin rsp_timer = 3; rsp_page = chk_pend_page; end
      if (tq_pend) begin
        n_tq++;
        chk(32'(tq_pend_page) == wr_idx, "R5 tq page", tq_pend_page, wr_idx);
        chk(cur_emap[last_page] == 1'b1, "R3 task only for corrected page", 0, 1);
        pushed = 1; tq_wait = 0;
      end
      chk_rsp_valid_i = 1'b0; fix_valid_i = 1'b0;
      if (rsp_timer > 0) rsp_timer--;
      else if (rsp_timer == 0) begin
        chk_rsp_valid_i = 1'b1; chk_rsp_err_i = cur_emap[rsp_page];
        rsp_stamp = cyc; rsp_timer = -1;
        if (cur_emap[rsp_page]) fix_timer = 4;
      end
      if (fix_timer > 0) fix_timer--;
      else if (fix_timer == 0) begin fix_valid_i = 1'b1; fix_stamp = cyc; fix_timer = -1; end
      chk_req_ready_i = (cyc % 3 == 2);
      chk_pend = chk_req_o && chk_req_ready_i; chk_pend_page = chk_page_o;
      tq_ready_i = tq_valid_o && (tq_wait >= 4);
      if (tq_valid_o && !tq_ready_i) tq_wait++;
      tq_pend = tq_valid_o && tq_ready_i; tq_pend_page = tq_page_o;

      if (chk_req_o && !req_prev)
        chk(cyc - rd_stamp == RD + 1, "R2 read to request delay", cyc - rd_stamp, RD + 1);
      req_prev = chk_req_o;

      if (nand_cmd_o) begin
        if (nand_op_o != 2'b10 && wr_stamp >= 0)
          chk(cyc - wr_stamp >= WR + 1, "R11 write busy gap", cyc - wr_stamp, WR + 1);
        if (nand_op_o == 2'b01) begin
          int e = -1;
          for (int i = 63; i >= 0; i--) if (exp_rem[i]) e = i;
          chk(32'(nand_page_o) == e, "R1 read page", nand_page_o, e);
          if (e >= 0) exp_rem[e] = 1'b0;
          last_page = nand_page_o; rd_stamp = cyc; n_rd++;
        end else if (nand_op_o == 2'b10) begin
          chk(32'(nand_page_o) == wr_idx, "R6 write destination", nand_page_o, wr_idx);
          chk(nand_wsrc_o == cur_emap[last_page], "R3 R4 write source", nand_wsrc_o,
              cur_emap[last_page]);
          if (!cur_emap[last_page])
            chk(cyc - rsp_stamp == 1, "R3 clean write delay", cyc - rsp_stamp, 1);
          else begin
            chk(pushed && fix_stamp > rsp_stamp, "R4 push and fix before write", pushed, 1);
          end
          pushed = 0; wr_idx++; n_wr++; wr_stamp = cyc;
        end else if (nand_op_o == 2'b11) begin
          n_er++; er_stamp = cyc;
        end
      end
      if (done_o && er_stamp >= 0)
        chk(cyc - er_stamp == ER + 1, "R7 erase to done delay", cyc - er_stamp, ER + 1);
    end
  end

  task automatic run(input logic [63:0] vm, em, input int fr, input int ec, ef, efull,
                     input int poke);
    int t;
    @(negedge clk);
    exp_rem = vm; cur_emap = em; wr_idx = 0; n_rd = 0; n_wr = 0; n_er = 0; n_tq = 0;
    rd_stamp = -1; er_stamp = -1; wr_stamp = -1; pushed = 0;
    @(negedge clk);
    start_i = 1'b1; valid_map_i = vm; dst_free_i = 7'(fr);
    @(negedge clk);
    start_i = 1'b0;
    t = 0;
    while (!done_o && t < 20000) begin
      @(negedge clk);
      t++;
      if (t == poke) begin
        start_i = 1'b1; valid_map_i = '1; dst_free_i = 7'd1;
      end else if (t == poke + 1) begin
        start_i = 1'b0;
      end
    end
    chk(done_o == 1'b1, "R7 pass completes", done_o, 1);
    @(negedge clk);
    chk(32'(clean_cnt_o) == ec, "R7 clean count", clean_cnt_o, ec);
    chk(32'(fixed_cnt_o) == ef, "R7 corrected count", fixed_cnt_o, ef);
    chk(32'(dst_full_o) == efull, "R8 full flag", dst_full_o, efull);
    chk(n_er == (efull ? 0 : 1), "R7 R8 erase count", n_er, efull ? 0 : 1);
    chk(n_wr == ec + ef, "R6 write count", n_wr, ec + ef);
    chk(n_tq == ef, "R5 one task per corrected page", n_tq, ef);
    chk(n_rd == ec + ef, "R1 R8 read count", n_rd, ec + ef);
    chk(busy_o == 1'b0, "R9 idle after pass", busy_o, 0);
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy_o == 0 && done_o == 0 && nand_cmd_o == 0, "R10 idle outputs", busy_o, 0);
    chk(chk_req_o == 0 && tq_valid_o == 0 && dst_full_o == 0, "R10 handshakes low", chk_req_o, 0);
    chk(clean_cnt_o == 0 && fixed_cnt_o == 0, "R10 counts zero", clean_cnt_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NV; v++)
      run(T_VMAP[v], T_EMAP[v], T_FREE[v], T_CLEAN[v], T_FIXED[v], T_FULL[v], 0);
    // R9 second start mid-pass has no effect
    run(64'h3, 64'h0, 64, 2, 0, 0, 10);
    // R8 full flag clears on the next pass
    run(64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0020, 3, 2, 1, 1, 0);
    run(64'h0000_0000_0000_0002, 64'h0, 1, 1, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule